// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus (clock line and open-drain data line). It gives a host access to a bank of 32 eight-bit configuration registers, for example the per-output enable bits of a clock generator. Both bus lines pass through a two-flop synchronizer and a short glitch filter. The slave then detects start, repeated start and stop conditions, matches its 7-bit address, and decodes a command byte. The top bit of the command byte selects one of two access modes: a single byte at an indexed offset, or a sequential block transfer that begins at register 0.

Block transfers carry a byte-count field ahead of the data in both directions. On a block write the host supplies the count, and the slave stores no more bytes than the count allows. On a block read the slave returns the size of the bank, then the registers in ascending order until the host answers a byte with a NACK. Every register holds its default value from reset, so a system that never uses the bus still works. The register contents are always visible on a flat output bus.

Top module: `cfg_smbus_slave`

## Requirements
- R1: The slave acknowledges only address bytes whose upper seven bits are 1101001 (0xD2 for a write, 0xD3 for a read). For any other address it leaves the acknowledge bit high and ignores all bits until the next start.
- R2: A command byte with bit 7 = 1 and bits 6:5 = 00 selects byte mode, with the register offset in bits 4:0. The data byte that follows is acknowledged and stored at that offset. Any further data byte is NACKed and not stored.
- R3: In byte mode, a repeated start followed by address 0xD3 returns the register at the command's offset, MSB first.
- R4: A command byte of 0x00 selects block mode. The next byte is a count N, which is acknowledged. The data bytes that follow are stored in registers 0, 1, 2 and upward, with at most min(N, 32) bytes acknowledged and stored. Bytes beyond that limit are NACKed and leave the registers unchanged.
- R5: In block mode, a repeated start followed by address 0xD3 returns the count byte 32 (0x20) first. It then returns the registers from index 0 upward, for as long as the master acknowledges each byte. After the master NACKs a byte, the slave releases the data line.
- R6: The slave NACKs a command byte that has bits 6:5 other than 00, or that selects block mode with bits 4:0 other than 00000. It then ignores the rest of the transaction, and no register changes.
- R7: A stop after any complete byte ends the transfer. Bytes that were already acknowledged stay stored.
- R8: After reset, register i holds 0xA0 XOR i, and the data line is released.
- R9: The slave changes its data-line drive only while the clock line is low. It releases the line whenever it is not sending an acknowledge or a 0 data bit.
- R10: A read address (0xD3) that does not follow an accepted command byte within the same transaction is NACKed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| cfg_o | output | 256 | Register contents; register i sits in bits 8i+7 down to 8i |

## Verification
A wrong bit counter or phase flag shifts the acknowledge by one bus clock. The master then sees a missing ACK, or a NACK read as data, within the same byte. A bad register pointer or count limit shows at the register output bus as soon as the byte that follows has been acknowledged. On a block read, it shows as the wrong value in the first data byte returned. A drive change while the clock line is high, or a line left driven after stop, shows at the data-line output within a few system clocks of the bus clock edge that caused it.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_WDATA,
    ST_TX
  } smb_state_e;

  // R8: power-up contents of register idx
  function automatic logic [7:0] reg_default(int unsigned idx);
    return 8'hA0 ^ 8'(idx);
  endfunction

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic          filt_q, filt_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    filt_n = filt_q;
    cnt_n  = cnt_q;
    if (sync_q[1] == filt_q) begin
      cnt_n = '0;
    end else if (cnt_q == CW'(FILT_LEN - 1)) begin
      filt_n = sync_q[1];
      cnt_n  = '0;
    end else begin
      cnt_n = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      filt_q <= filt_n;
      cnt_q  <= cnt_n;
    end
  end

  assign filt_o = filt_q;

  // R9: the filtered line flips only after the synchronized input has disagreed with it
  a_r9_filter_settle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> $past(sync_q[1]) == filt_q);

endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_start,
  output logic ev_stop
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign ev_rise  = scl_f & ~scl_p;
  assign ev_fall  = ~scl_f & scl_p;
  assign ev_start = scl_f & scl_p & sda_p & ~sda_f;
  assign ev_stop  = scl_f & scl_p & ~sda_p & sda_f;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int unsigned NREG = 32,
  localparam int unsigned AW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [7:0]      wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [7:0]      rd_data,
  output logic [NREG*8-1:0] flat_o
);
  import smb_cfg_pkg::*;

  logic [7:0] mem_q [NREG];

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_q[g] <= reg_default(g);
        end else if (wr_en && (wr_addr == AW'(g))) begin
          mem_q[g] <= wr_data;
        end
      end
      assign flat_o[g*8 +: 8] = mem_q[g];
    end
  endgenerate

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/smb_proto_engine.sv
module smb_proto_engine #(
  parameter int unsigned NREG     = 32,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  localparam int unsigned AW = $clog2(NREG),
  localparam int unsigned RW = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_f,
  input  logic          sda_f,
  input  logic          ev_rise,
  input  logic          ev_fall,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_oe
);
  import smb_cfg_pkg::*;

  localparam logic [7:0] NREG_B = 8'(NREG);

  smb_state_e    state_q, state_n;
  logic [3:0]    bitcnt_q, bitcnt_n;
  logic [7:0]    shreg_q, shreg_n;
  logic [7:0]    tx_q, tx_n;
  logic          in_ack_q, in_ack_n;
  logic          drive_q, drive_n;
  logic [AW-1:0] ptr_q, ptr_n;
  logic [RW-1:0] remain_q, remain_n;
  logic          cmd_ok_q, cmd_ok_n;
  logic          blk_q, blk_n;
  logic          rw_q, rw_n;
  logic          mack_q, mack_n;
  logic [7:0]    ld_byte;

  assign rd_addr = ptr_q;
  assign wr_addr = ptr_q;
  assign wr_data = shreg_q;
  assign sda_oe  = drive_q;

  // next-state logic
  always_comb begin
    state_n  = state_q;
    bitcnt_n = bitcnt_q;
    shreg_n  = shreg_q;
    tx_n     = tx_q;
    in_ack_n = in_ack_q;
    drive_n  = drive_q;
    ptr_n    = ptr_q;
    remain_n = remain_q;
    cmd_ok_n = cmd_ok_q;
    blk_n    = blk_q;
    rw_n     = rw_q;
    mack_n   = mack_q;
    wr_en    = 1'b0;
    ld_byte  = rd_data;

    if (ev_stop) begin
      state_n  = ST_IDLE;
      drive_n  = 1'b0;
      in_ack_n = 1'b0;
      cmd_ok_n = 1'b0;
    end else if (ev_start) begin
      state_n  = ST_ADDR;
      bitcnt_n = '0;
      in_ack_n = 1'b0;
      drive_n  = 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (ev_rise) begin
        if (in_ack_q) begin
          if (state_q == ST_TX) mack_n = ~sda_f;
        end else begin
          bitcnt_n = bitcnt_q + 4'd1;
          if (state_q != ST_TX) shreg_n = {shreg_q[6:0], sda_f};
        end
      end
      if (ev_fall) begin
        if (in_ack_q) begin
          // end of the acknowledge clock
          in_ack_n = 1'b0;
          drive_n  = 1'b0;
          bitcnt_n = '0;
          case (state_q)
            ST_ADDR: begin
              if (rw_q) begin
                state_n = ST_TX;
                if (blk_q) begin
                  ld_byte = NREG_B;           // R5: count byte first
                end else begin
                  ptr_n = ptr_q + AW'(1);
                end
                drive_n = ~ld_byte[7];
                tx_n    = {ld_byte[6:0], 1'b0};
              end else begin
                state_n = ST_CMD;
              end
            end
            ST_CMD:  state_n = blk_q ? ST_CNT : ST_WDATA;
            ST_CNT:  state_n = ST_WDATA;
            ST_TX: begin
              if (mack_q) begin
                ptr_n   = ptr_q + AW'(1);
                drive_n = ~ld_byte[7];
                tx_n    = {ld_byte[6:0], 1'b0};
              end else begin
                state_n = ST_IDLE;
              end
            end
            default: ;
          endcase
        end else if (bitcnt_q == 4'd8) begin
          bitcnt_n = '0;
          in_ack_n = 1'b1;
          drive_n  = 1'b0;
          case (state_q)
            ST_ADDR: begin
              rw_n = shreg_q[0];
              // R1, R10
              if (shreg_q[7:1] == DEV_ADDR && (!shreg_q[0] || cmd_ok_q)) begin
                drive_n = 1'b1;
              end else begin
                state_n  = ST_IDLE;
                in_ack_n = 1'b0;
              end
            end
            ST_CMD: begin
              // R6: chip-select field and block offset checks
              if (shreg_q[6:5] == 2'b00 && (shreg_q[7] || shreg_q[4:0] == 5'd0)) begin
                drive_n  = 1'b1;
                cmd_ok_n = 1'b1;
                blk_n    = ~shreg_q[7];
                ptr_n    = shreg_q[7] ? AW'(shreg_q[4:0]) : '0;
                remain_n = RW'(1);
              end else begin
                state_n  = ST_IDLE;
                in_ack_n = 1'b0;
                cmd_ok_n = 1'b0;
              end
            end
            ST_CNT: begin
              drive_n  = 1'b1;
              remain_n = (shreg_q > NREG_B) ? RW'(NREG) : RW'(shreg_q);
            end
            ST_WDATA: begin
              if (remain_q != '0) begin
                drive_n  = 1'b1;
                wr_en    = 1'b1;
                ptr_n    = ptr_q + AW'(1);
                remain_n = remain_q - RW'(1);
              end
            end
            default: ;  // ST_TX: release for the master's acknowledge
          endcase
        end else if (state_q == ST_TX && bitcnt_q != 4'd0) begin
          drive_n = ~tx_q[7];
          tx_n    = {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      tx_q     <= '0;
      in_ack_q <= 1'b0;
      drive_q  <= 1'b0;
      ptr_q    <= '0;
      remain_q <= '0;
      cmd_ok_q <= 1'b0;
      blk_q    <= 1'b0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
    end else begin
      state_q  <= state_n;
      bitcnt_q <= bitcnt_n;
      shreg_q  <= shreg_n;
      tx_q     <= tx_n;
      in_ack_q <= in_ack_n;
      drive_q  <= drive_n;
      ptr_q    <= ptr_n;
      remain_q <= remain_n;
      cmd_ok_q <= cmd_ok_n;
      blk_q    <= blk_n;
      rw_q     <= rw_n;
      mack_q   <= mack_n;
    end
  end

  // R9: drive changes only with the clock line low, or on a bus condition
  a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drive_q) |-> (!scl_f || $past(ev_start || ev_stop)));

  // R10: data is never sent without an accepted command
  a_r10_tx_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TX) |-> cmd_ok_q);

  // R4: the write allowance never exceeds the bank size
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    remain_q <= RW'(NREG));

  // R2: every stored byte is acknowledged on the line
  a_r2_store_acked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> drive_q);

endmodule

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave #(
  parameter int unsigned NREG     = 32,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [NREG*8-1:0] cfg_o
);
  localparam int unsigned AW = $clog2(NREG);

  logic          rst_meta, rst_s;
  logic [1:0]    raw_w, filt_w;
  logic          ev_rise, ev_fall, ev_start, ev_stop;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  assign raw_w = {scl_i, sda_i};

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_line
      smb_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk    (clk),
        .rst_n  (rst_s),
        .raw_i  (raw_w[g]),
        .filt_o (filt_w[g])
      );
    end
  endgenerate

  smb_bus_events u_ev (
    .clk      (clk),
    .rst_n    (rst_s),
    .scl_f    (filt_w[1]),
    .sda_f    (filt_w[0]),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall),
    .ev_start (ev_start),
    .ev_stop  (ev_stop)
  );

  smb_proto_engine #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk      (clk),
    .rst_n    (rst_s),
    .scl_f    (filt_w[1]),
    .sda_f    (filt_w[0]),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sda_oe   (sda_oe)
  );

  smb_reg_bank #(.NREG(NREG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_s),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .flat_o  (cfg_o)
  );

endmodule

// File: tb/cfg_smbus_slave_tb.sv
module cfg_smbus_slave_tb_top;

  localparam int Q = 12;

  logic clk, rst_n, scl_m, sda_m;
  logic sda_oe, sda_line;
  logic [255:0] cfg_o;
  int n_cmp = 0, n_bad = 0, viol = 0;
  logic prev_oe;
  bit done = 0;

  assign sda_line = sda_m & ~sda_oe;

  cfg_smbus_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_o(cfg_o)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // R9 monitor: drive changes while the raw clock line is high
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && scl_m) viol++;
    prev_oe = sda_oe;
  end

  function automatic logic [7:0] rb(int i);
    return cfg_o[i*8 +: 8];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic qw; repeat (Q) @(negedge clk); endtask

  task automatic m_start;
    sda_m = 1; qw; scl_m = 1; qw; sda_m = 0; qw; scl_m = 0; qw;
  endtask

  task automatic m_stop;
    sda_m = 0; qw; scl_m = 1; qw; sda_m = 1; qw; qw;
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; qw; scl_m = 1; qw; r = sda_line; qw; scl_m = 0; qw;
  endtask

  task automatic m_wbyte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(d[i], r);
    m_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic m_rbyte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin m_bit(1'b1, r); d[i] = r; end
    m_bit(~mack, r);
  endtask

  task automatic t_reset;
    chk("R8 oe", {31'd0, sda_oe}, 32'd0);
    for (int i = 0; i < 32; i++) chk("R8 default", {24'd0, rb(i)}, {24'd0, 8'hA0 ^ 8'(i)});
  endtask

  task automatic t_bad_addr;
    logic a;
    m_start; m_wbyte(8'hA4, a); chk("R1 foreign addr nack", {31'd0, a}, 32'd0);
    m_wbyte(8'h85, a); chk("R1 ignored byte", {31'd0, a}, 32'd0);
    m_stop;
    chk("R1 reg5 untouched", {24'd0, rb(5)}, 32'hA5);
  endtask

  task automatic t_byte_write;
    logic a;
    m_start; m_wbyte(8'hD2, a); chk("R1 addr ack", {31'd0, a}, 32'd1);
    m_wbyte(8'h85, a); chk("R2 cmd ack", {31'd0, a}, 32'd1);
    m_wbyte(8'h3C, a); chk("R2 data ack", {31'd0, a}, 32'd1);
    m_wbyte(8'h77, a); chk("R2 extra nack", {31'd0, a}, 32'd0);
    m_stop;
    chk("R2 reg5", {24'd0, rb(5)}, 32'h3C);
    chk("R2 reg6 kept", {24'd0, rb(6)}, 32'hA6);
    chk("R9 released after stop", {31'd0, sda_oe}, 32'd0);
  endtask

  task automatic t_byte_read(input logic [7:0] cmd, input logic [7:0] exp);
    logic a; logic [7:0] d;
    m_start; m_wbyte(8'hD2, a); m_wbyte(cmd, a);
    m_start; m_wbyte(8'hD3, a); chk("R3 read addr ack", {31'd0, a}, 32'd1);
    m_rbyte(1'b0, d); chk("R3 read data", {24'd0, d}, {24'd0, exp});
    m_stop;
    chk("R5 released after nack", {31'd0, sda_oe}, 32'd0);
  endtask

  task automatic t_block_write;
    logic a;
    m_start; m_wbyte(8'hD2, a);
    m_wbyte(8'h00, a); chk("R4 cmd ack", {31'd0, a}, 32'd1);
    m_wbyte(8'h03, a); chk("R4 count ack", {31'd0, a}, 32'd1);
    m_wbyte(8'h11, a); m_wbyte(8'h22, a); m_wbyte(8'h33, a);
    chk("R4 last allowed ack", {31'd0, a}, 32'd1);
    m_wbyte(8'h44, a); chk("R4 beyond count nack", {31'd0, a}, 32'd0);
    m_stop;
    chk("R4 reg0", {24'd0, rb(0)}, 32'h11);
    chk("R4 reg1", {24'd0, rb(1)}, 32'h22);
    chk("R4 reg2", {24'd0, rb(2)}, 32'h33);
    chk("R4 reg3 kept", {24'd0, rb(3)}, 32'hA3);
  endtask

  task automatic t_block_read;
    logic a; logic [7:0] d;
    m_start; m_wbyte(8'hD2, a); m_wbyte(8'h00, a);
    m_start; m_wbyte(8'hD3, a); chk("R5 addr ack", {31'd0, a}, 32'd1);
    m_rbyte(1'b1, d); chk("R5 count byte", {24'd0, d}, 32'h20);
    m_rbyte(1'b1, d); chk("R5 byte0", {24'd0, d}, 32'h11);
    m_rbyte(1'b1, d); chk("R5 byte1", {24'd0, d}, 32'h22);
    m_rbyte(1'b1, d); chk("R5 byte2", {24'd0, d}, 32'h33);
    m_rbyte(1'b0, d); chk("R5 byte3", {24'd0, d}, 32'hA3);
    m_stop;
    chk("R5 released", {31'd0, sda_oe}, 32'd0);
  endtask

  task automatic t_bad_cmd;
    logic a;
    m_start; m_wbyte(8'hD2, a);
    m_wbyte(8'hA5, a); chk("R6 chip-select nack", {31'd0, a}, 32'd0);
    m_wbyte(8'h99, a); chk("R6 ignored data", {31'd0, a}, 32'd0);
    m_stop;
    chk("R6 reg5 kept", {24'd0, rb(5)}, 32'h3C);
    m_start; m_wbyte(8'hD2, a);
    m_wbyte(8'h03, a); chk("R6 block offset nack", {31'd0, a}, 32'd0);
    m_wbyte(8'h01, a); m_wbyte(8'h99, a);
    m_stop;
    chk("R6 reg0 kept", {24'd0, rb(0)}, 32'h11);
  endtask

  task automatic t_early_stop;
    logic a;
    m_start; m_wbyte(8'hD2, a); m_wbyte(8'h00, a); m_wbyte(8'h04, a);
    m_wbyte(8'h55, a); m_wbyte(8'h66, a); chk("R7 ack before stop", {31'd0, a}, 32'd1);
    m_stop;
    chk("R7 reg0", {24'd0, rb(0)}, 32'h55);
    chk("R7 reg1", {24'd0, rb(1)}, 32'h66);
    chk("R7 reg2 kept", {24'd0, rb(2)}, 32'h33);
  endtask

  task automatic t_read_no_cmd;
    logic a;
    m_start; m_wbyte(8'hD3, a); chk("R10 read without cmd nack", {31'd0, a}, 32'd0);
    m_stop;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run;
  end

  initial begin
    scl_m = 1; sda_m = 1; rst_n = 0; prev_oe = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (10) @(negedge clk);
    t_reset;
    t_bad_addr;
    t_byte_write;
    t_byte_read(8'h85, 8'h3C);
    t_byte_read(8'h9F, 8'hBF);
    t_block_write;
    t_block_read;
    t_bad_cmd;
    t_early_stop;
    t_read_no_cmd;
    chk("R9 drive change with clock high", viol, 32'd0);
    finish_run;
  end

endmodule